// File: doc/BRIEF.md
# Dual-Bank Streaming Row Histogram

This block sits in a gradient-feature pipeline between the per-pixel stage that yields a gradient magnitude with an orientation bin and the later stages that buffer cells and columns. It takes one (magnitude, bin index, valid) tuple per clock. For each run of eight valid pixels along a row it produces a nine-bin partial histogram, which is the sum of the magnitudes that fell into each orientation bin.

Two identical accumulator banks take turns. A pixel counter steers each group of eight valid pixels to one bank, and the next group goes to the other bank. A finished bank shows its sums for one cycle and clears itself on the cycle after that, while its partner is already taking input. The stream therefore never has to pause. An output multiplexer forwards the sums of whichever bank is presenting. In every other cycle the output bus reads zero.

Top module: `row_hist_dual`

## Requirements
- R1: A synchronous active-low reset empties both banks, sets the pixel counter to zero and selects the first bank. While reset is held, and in the first cycle after it, `hist_valid` is 0 and `hist_bins` is 0. Pixels of a group that reset interrupted never show up in a later histogram.
- R2: The block accepts a pixel in every cycle in which `px_valid` is 1. For each eight accepted pixels, `hist_valid` is 1 in exactly the cycle that follows the cycle in which the eighth pixel was presented. In every other cycle it is 0.
- R3: While `hist_valid` is 1, bin k (for k = 0..8) sits at `hist_bins[16*k+15:16*k]`. Its value is the sum of `px_mag` over the eight pixels of that group whose `px_bin` equals k, with 0 for a bin that no pixel hit.
- R4: A cycle with `px_valid` = 0 does not advance the group and adds nothing to any bin, whatever `px_mag` and `px_bin` carry. A group's result still appears one cycle after its eighth valid pixel, even when invalid cycles follow.
- R5: A valid pixel whose `px_bin` is in the range 9..15 counts toward the eight pixels of its group but adds to no bin.
- R6: Groups that arrive back to back with no gap produce `hist_valid` pulses exactly 8 cycles apart. Each histogram holds only its own group's pixels, because a bank is cleared before it is used again.
- R7: In every cycle in which `hist_valid` is 0, `hist_bins` is all zeros.
- R8: Every `hist_valid` pulse lasts one cycle. Two consecutive cycles never both have `hist_valid` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all registers update on its rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| px_valid | input | 1 | The pixel tuple is present in this cycle |
| px_mag | input | 9 | Gradient magnitude of the pixel, unsigned |
| px_bin | input | 4 | Orientation bin index; 0..8 select a bin, 9..15 select none |
| hist_valid | output | 1 | One-cycle pulse: `hist_bins` holds a finished group |
| hist_bins | output | 144 | Nine unsigned 16-bit bin sums, bin k at bits 16k+15..16k |

## Verification
A group's histogram is due in the single cycle after the one in which its eighth valid pixel is presented, and no other output is due. The bench changes inputs and samples outputs on the falling edge. It records the group that the current drive completed as pending and compares that record with the outputs at the next falling edge. That comparison covers one register stage. In every cycle with nothing pending, the bench requires `hist_valid` to be low and `hist_bins` to be zero. This checks the latency and the idle behaviour every cycle, including cycles with gaps, illegal bin indices and resets in the middle of a group.

// File: rtl/rowhist_pkg.sv
// Package: rowhist_pkg
// Shared sizing for the dual-bank row histogram. It assumes a group size that
// is a power of two and a sum width that can hold GROUP times the largest
// magnitude.
package rowhist_pkg;
    localparam int NBINS  = 9;   // orientation bins per histogram
    localparam int IDX_W  = 4;   // width of the bin index
    localparam int MAG_W  = 9;   // width of a pixel magnitude
    localparam int SUM_W  = 16;  // width of one bin sum
    localparam int GROUP  = 8;   // valid pixels per histogram
    localparam int NBANKS = 2;   // accumulator banks in rotation
endpackage

// File: rtl/rowhist_steer.sv
// Module: rowhist_steer
// Counts valid pixels and routes each group of GROUP pixels to one bank,
// moving to the next bank in turn whenever a group completes. It assumes
// GROUP is a power of two, so the counter wraps on its own, and NBANKS >= 2.
module rowhist_steer #(
    parameter int GROUP  = 8,
    parameter int NBANKS = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              px_valid,
    output logic [NBANKS-1:0] bank_acc,
    output logic              group_last
);
    localparam int CNT_W = $clog2(GROUP);
    localparam int SEL_W = (NBANKS > 1) ? $clog2(NBANKS) : 1;

    logic [CNT_W-1:0] cnt_q;
    logic [SEL_W-1:0] sel_q;
    logic             wrap;

    // Purpose: detect the last pixel of the current group
    always_comb begin
        wrap       = (cnt_q == CNT_W'(GROUP - 1));
        group_last = px_valid && wrap;
    end

    // Purpose: one-hot accumulate enable for the bank that owns this pixel
    always_comb begin
        bank_acc = '0;
        for (int b = 0; b < NBANKS; b++) begin
            if (px_valid && (sel_q == SEL_W'(b))) bank_acc[b] = 1'b1;
        end
    end

    // Purpose: advance the pixel counter and rotate banks on wrap
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            sel_q <= '0;
        end else if (px_valid) begin
            cnt_q <= cnt_q + CNT_W'(1);
            if (wrap) begin
                sel_q <= (sel_q == SEL_W'(NBANKS - 1)) ? '0 : sel_q + SEL_W'(1);
            end
        end
    end
endmodule

// File: rtl/rowhist_bank.sv
// Module: rowhist_bank
// One accumulator bank with NBINS bin registers. It adds the pixel magnitude
// to the bin that the index selects and ignores indices of NBINS or more.
// After the last pixel it presents its sums for one cycle and clears them
// in the cycle after that. It assumes the steering logic never sends it a
// pixel while it is clearing.
module rowhist_bank #(
    parameter int NBINS = 9,
    parameter int IDX_W = 4,
    parameter int MAG_W = 9,
    parameter int SUM_W = 16
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   acc_en,
    input  logic                   last,
    input  logic [MAG_W-1:0]       mag,
    input  logic [IDX_W-1:0]       idx,
    output logic                   presenting,
    output logic                   clearing,
    output logic [NBINS*SUM_W-1:0] sums
);
    // Purpose: sequence the present cycle and the clear cycle after a group
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            presenting <= 1'b0;
            clearing   <= 1'b0;
        end else begin
            presenting <= acc_en && last;
            clearing   <= presenting;
        end
    end

    for (genvar k = 0; k < NBINS; k++) begin : g_bin
        logic [SUM_W-1:0] acc_q;
        logic             hit;

        // Purpose: decode whether this pixel belongs to bin k
        always_comb hit = acc_en && (idx == IDX_W'(k));

        // Purpose: accumulate or clear bin k
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                acc_q <= '0;
            end else if (clearing) begin
                acc_q <= '0;
            end else if (hit) begin
                acc_q <= acc_q + SUM_W'(mag);
            end
        end

        assign sums[k*SUM_W +: SUM_W] = acc_q;
    end
endmodule

// File: rtl/rowhist_outmux.sv
// Module: rowhist_outmux
// Forwards the sums of whichever bank is presenting and drives zeros when no
// bank is. It assumes at most one bank presents in any cycle.
module rowhist_outmux #(
    parameter int NBANKS = 2,
    parameter int W      = 144
) (
    input  logic [NBANKS-1:0]   present,
    input  logic [NBANKS*W-1:0] bank_sums,
    output logic                out_valid,
    output logic [W-1:0]        out_data
);
    // Purpose: AND-OR select of the presenting bank
    always_comb begin
        out_data = '0;
        for (int b = 0; b < NBANKS; b++) begin
            if (present[b]) out_data = out_data | bank_sums[b*W +: W];
        end
        out_valid = |present;
    end
endmodule

// File: rtl/row_hist_dual.sv
// Module: row_hist_dual
// Top level of the dual-bank row histogram. It takes one pixel tuple per
// clock and sends each group of GROUP valid pixels to one of NBANKS
// accumulator banks in turn. A group's nine-bin histogram appears on the
// cycle after its last pixel. It assumes SUM_W can hold GROUP*(2**MAG_W-1).
module row_hist_dual
    import rowhist_pkg::*;
#(
    parameter int P_NBINS  = NBINS,
    parameter int P_IDX_W  = IDX_W,
    parameter int P_MAG_W  = MAG_W,
    parameter int P_SUM_W  = SUM_W,
    parameter int P_GROUP  = GROUP,
    parameter int P_NBANKS = NBANKS
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       px_valid,
    input  logic [P_MAG_W-1:0]         px_mag,
    input  logic [P_IDX_W-1:0]         px_bin,
    output logic                       hist_valid,
    output logic [P_NBINS*P_SUM_W-1:0] hist_bins
);
    localparam int HIST_W = P_NBINS * P_SUM_W;

    logic [P_NBANKS-1:0]        bank_acc;
    logic                       group_last;
    logic [P_NBANKS-1:0]        bank_present;
    logic [P_NBANKS-1:0]        bank_clear;
    logic [P_NBANKS*HIST_W-1:0] bank_sums;

    rowhist_steer #(
        .GROUP (P_GROUP),
        .NBANKS(P_NBANKS)
    ) u_steer (
        .clk       (clk),
        .rst_n     (rst_n),
        .px_valid  (px_valid),
        .bank_acc  (bank_acc),
        .group_last(group_last)
    );

    for (genvar b = 0; b < P_NBANKS; b++) begin : g_bank
        rowhist_bank #(
            .NBINS(P_NBINS),
            .IDX_W(P_IDX_W),
            .MAG_W(P_MAG_W),
            .SUM_W(P_SUM_W)
        ) u_bank (
            .clk       (clk),
            .rst_n     (rst_n),
            .acc_en    (bank_acc[b]),
            .last      (group_last),
            .mag       (px_mag),
            .idx       (px_bin),
            .presenting(bank_present[b]),
            .clearing  (bank_clear[b]),
            .sums      (bank_sums[b*HIST_W +: HIST_W])
        );
    end

    rowhist_outmux #(
        .NBANKS(P_NBANKS),
        .W     (HIST_W)
    ) u_outmux (
        .present  (bank_present),
        .bank_sums(bank_sums),
        .out_valid(hist_valid),
        .out_data (hist_bins)
    );
endmodule

// File: rtl/rowhist_checker.sv
// Module: rowhist_checker
// Protocol checks for row_hist_dual, attached through bind. It keeps its own
// count of valid pixels so that it can place each expected pulse.
module rowhist_checker #(
    parameter int GROUP  = 8,
    parameter int NBANKS = 2,
    parameter int HIST_W = 144
) (
    input logic              clk,
    input logic              rst_n,
    input logic              px_valid,
    input logic              hist_valid,
    input logic [HIST_W-1:0] hist_bins,
    input logic [NBANKS-1:0] bank_acc,
    input logic [NBANKS-1:0] bank_present,
    input logic [NBANKS-1:0] bank_clear
);
    localparam int CNT_W = $clog2(GROUP);
    logic [CNT_W-1:0] chk_cnt;

    // Purpose: independent count of valid pixels, modulo GROUP
    always_ff @(posedge clk) begin
        if (!rst_n)        chk_cnt <= '0;
        else if (px_valid) chk_cnt <= chk_cnt + CNT_W'(1);
    end

    AST_PULSE_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n)
        hist_valid == ($past(px_valid) && ($past(chk_cnt) == CNT_W'(GROUP - 1)))); // R2
    AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        hist_valid |=> !hist_valid); // R8
    AST_IDLE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !hist_valid |-> (hist_bins == '0)); // R7
    AST_ONE_PRESENTER: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(bank_present)); // R6
    AST_NO_ADD_WHILE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (bank_acc & bank_clear) == '0); // R6
endmodule

bind row_hist_dual rowhist_checker #(
    .GROUP (P_GROUP),
    .NBANKS(P_NBANKS),
    .HIST_W(P_NBINS * P_SUM_W)
) u_rowhist_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .px_valid    (px_valid),
    .hist_valid  (hist_valid),
    .hist_bins   (hist_bins),
    .bank_acc    (bank_acc),
    .bank_present(bank_present),
    .bank_clear  (bank_clear)
);

// File: tb/row_hist_dual_test.sv
// Bench: row_hist_dual_test
// Drives pixel streams on the falling edge and keeps a per-group reference
// histogram. Each output sample is compared with the group that the previous
// drive completed.
module row_hist_dual_test;
    localparam int NB = 9;
    localparam int SW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          px_valid = 1'b0;
    logic [8:0]    px_mag = '0;
    logic [3:0]    px_bin = '0;
    logic          hist_valid;
    logic [NB*SW-1:0] hist_bins;

    int n_tests = 0;
    int n_fail  = 0;
    int cycles  = 0;
    bit done    = 1'b0;

    // reference model
    int  m_hist [NB];
    int  m_cnt  = 0;
    bit  pend   = 1'b0;
    int  p_hist [NB];
    int  last_pulse = -100;
    string tag  = "R1";

    always #2 clk = ~clk;

    row_hist_dual uut (
        .clk       (clk),
        .rst_n     (rst_n),
        .px_valid  (px_valid),
        .px_mag    (px_mag),
        .px_bin    (px_bin),
        .hist_valid(hist_valid),
        .hist_bins (hist_bins)
    );

    task automatic model_clear();
        for (int k = 0; k < NB; k++) m_hist[k] = 0;
        m_cnt = 0;
    endtask

    // compare outputs with the pending expectation
    task automatic check_out();
        n_tests++;
        if (hist_valid !== pend) begin
            n_fail++;
            $display("FAIL %s/R2: hist_valid=%0b expected %0b at cycle %0d", tag, hist_valid, pend, cycles);
        end
        n_tests++;
        if (pend) begin
            for (int k = 0; k < NB; k++) begin
                if (int'(hist_bins[k*SW +: SW]) != p_hist[k]) begin
                    n_fail++;
                    $display("FAIL %s/R3: bin %0d = %0d expected %0d", tag, k, hist_bins[k*SW +: SW], p_hist[k]);
                    break;
                end
            end
            if (tag == "R6") begin
                n_tests++;
                if (last_pulse >= 0 && cycles - last_pulse != 8) begin
                    n_fail++;
                    $display("FAIL R6: pulse spacing %0d expected 8", cycles - last_pulse);
                end
            end
            last_pulse = cycles;
        end else if (hist_bins !== '0) begin
            n_fail++;
            $display("FAIL %s/R7: idle bins %h expected 0", tag, hist_bins);
        end
    endtask

    // one cycle: sample, then drive new inputs and update the model
    task automatic step(input bit v, input int b, input int m);
        @(negedge clk);
        check_out();
        px_valid = v;
        px_bin   = 4'(b);
        px_mag   = 9'(m);
        pend = 1'b0;
        if (rst_n && v) begin
            if (b < NB) m_hist[b] += m;
            m_cnt++;
            if (m_cnt == 8) begin
                for (int k = 0; k < NB; k++) p_hist[k] = m_hist[k];
                pend = 1'b1;
                model_clear();
            end
        end
    endtask

    task automatic do_reset(input int n);
        @(negedge clk);
        check_out();
        rst_n = 1'b0;
        px_valid = 1'b0;
        pend = 1'b0;
        model_clear();
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check_out();
        end
        rst_n = 1'b1;
    endtask

    logic [15:0] lfsr = 16'hACE1;
    function automatic logic [15:0] nxt(input logic [15:0] s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    initial begin
        model_clear();
        // R1: reset state and the first cycle after it
        tag = "R1";
        do_reset(3);
        step(1'b0, 0, 0);
        // R3: every bin paired with every position, at the largest magnitude and near it
        tag = "R3";
        for (int rot = 0; rot < NB; rot++) begin
            for (int p = 0; p < 8; p++) step(1'b1, (rot + p) % NB, 511 - p * 3);
        end
        // R3: all pixels into one bin at full scale, 8*511 = 4088, for each bin
        for (int b = 0; b < NB; b++) begin
            for (int p = 0; p < 8; p++) step(1'b1, b, 511);
        end
        // R3: all-zero magnitudes
        for (int p = 0; p < 8; p++) step(1'b1, p, 0);
        step(1'b0, 0, 0);
        step(1'b0, 0, 0);
        // R6: long back-to-back run, no gaps
        tag = "R6";
        last_pulse = -1;
        for (int i = 0; i < 8 * 40; i++) begin
            lfsr = nxt(lfsr);
            step(1'b1, int'(lfsr[3:0]) % NB, int'(lfsr[12:4]));
        end
        last_pulse = -100;
        // R4: invalid cycles with junk values, random gaps
        tag = "R4";
        for (int i = 0; i < 2000; i++) begin
            lfsr = nxt(lfsr);
            step(lfsr[0] & lfsr[5], int'(lfsr[11:8]) % NB, int'(lfsr[15:7]));
        end
        // R4: eighth pixel followed by a long gap with junk values
        for (int p = 0; p < 8; p++) step(1'b1, 8 - p, 100 + p);
        for (int i = 0; i < 12; i++) step(1'b0, i % NB, 511);
        // R5: out-of-range indices count as pixels but add nothing
        tag = "R5";
        for (int g = 0; g < 14; g++) begin
            for (int p = 0; p < 8; p++) begin
                lfsr = nxt(lfsr);
                step(1'b1, (p % 2 == 0) ? 9 + (g + p) % 7 : p, int'(lfsr[8:0]));
            end
        end
        for (int p = 0; p < 8; p++) step(1'b1, 15, 511);
        step(1'b0, 0, 0);
        // R1: reset in the middle of a group discards its pixels
        tag = "R1";
        for (int p = 0; p < 5; p++) step(1'b1, 3, 200);
        do_reset(2);
        for (int p = 0; p < 8; p++) step(1'b1, p, 10 + p);
        step(1'b0, 0, 0);
        // R8: the pulse lasts one cycle and is then checked idle
        tag = "R8";
        for (int p = 0; p < 8; p++) step(1'b1, 4, 7);
        step(1'b0, 0, 0);
        step(1'b0, 0, 0);
        step(1'b0, 0, 0);
        if (!done) begin
            done = 1'b1;
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    // watchdog
    always @(posedge clk) begin
        cycles++;
        if (cycles > 200000 && !done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog expired at cycle %0d", cycles);
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule